// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes incoming Ethernet frames as a byte stream and stores the accepted ones in a circular buffer made of 256-byte pages in packet memory. When a frame starts, the block first checks that reception is enabled and that the ring has room. It then filters on the destination address: it can accept all frames, broadcast frames, multicast frames whose CRC-32 hash hits a 64-bit hash table, or unicast frames that match the station address.

An accepted frame is written four bytes past the start of the current page. Frames shorter than the minimum size are padded with zeros. A four-byte header then goes in front of the data, holding the status, the next free page and the stored length. After that the block publishes the new current page and the status byte and raises a one-cycle completion pulse. A host uses the block by programming the ring page bounds, boundary and current page, and then reading frames back from memory.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame whose first byte is presented while `halt_i` is 1 is consumed with no memory write and no `rx_done_o`.
- R2: A frame is consumed with no memory write when stop page <= start page, or when the free space is below 1518 bytes. Free space is (boundary - current) * 256 when current < boundary, and otherwise ((stop - start) - (current - boundary)) * 256.
- R3: With `rx_mode_i[2]` set, every frame is accepted whatever its destination.
- R4: Without `rx_mode_i[2]`, a destination of all ones (broadcast) is accepted only when `rx_mode_i[0]` is 1.
- R5: Without `rx_mode_i[2]`, a non-broadcast destination whose first byte has bit 0 set (group) is accepted only when `rx_mode_i[1]` is 1 and `mc_hash_i[h]` is 1. Here h is bits 31:26 of a CRC-32 over the six destination bytes: polynomial 0x04C11DB7, preset all ones, bytes taken LSB first, no final inversion.
- R6: Without `rx_mode_i[2]`, any other destination is accepted only when it equals `sta_addr_i`, where destination byte k is compared with `sta_addr_i[8k+7:8k]` and byte 0 is the first byte on the wire.
- R7: An accepted frame shorter than 60 bytes is stored padded with zero bytes to 60. The stored total length is the padded length plus 4.
- R8: The header sits at current page * 256: byte 0 is status, byte 1 is next page, byte 2 is total length low, byte 3 is total length high. Status is 0x01, or 0x21 when the destination group bit is 1. Frame data starts at offset 4.
- R9: Next page = current page + ceil((total length + 4) / 256). When the result reaches or exceeds the stop page, (stop - start) is subtracted from it.
- R10: Every memory write lies in [start*256, stop*256). A data write address that reaches stop*256 continues at start*256.
- R11: After the last header byte, `cur_pg_o` takes the next page, `rx_status_o` takes the status, and `rx_done_o` pulses for exactly one cycle. Rejected or dropped frames change neither output and give no pulse.
- R12: A frame that ends before 6 bytes or exceeds 1514 bytes is discarded without a header, a page advance or `rx_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Reception halted |
| rx_mode_i | input | 3 | Bit 0 broadcast, bit 1 multicast, bit 2 accept all |
| ring_start_pg_i | input | 8 | First page of the ring |
| ring_stop_pg_i | input | 8 | Page one past the end of the ring |
| bnd_pg_i | input | 8 | Boundary page (oldest page not yet read) |
| cur_pg_i | input | 8 | Current write page, sampled at frame start |
| sta_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| mc_hash_i | input | 64 | Multicast hash table, bit h for hash index h |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Last byte of frame |
| s_ready_o | output | 1 | Stream byte accepted when high with valid |
| mem_we_o | output | 1 | Packet memory write strobe |
| mem_addr_o | output | 16 | Packet memory byte address |
| mem_data_o | output | 8 | Packet memory write data |
| cur_pg_o | output | 8 | Updated current page |
| rx_status_o | output | 8 | Status of the last stored frame |
| rx_done_o | output | 1 | One-cycle pulse per stored frame |

## Verification
The hardest cases to reach are the ring wrap and the free-space edge. A wrap needs a frame that starts on the last ring page, so that both the data address and the next-page sum cross the stop page. The edge case needs a boundary that leaves exactly 1280 bytes free, and then exactly 1536. The stimulus gets there by moving the current-page and boundary inputs directly between frames, instead of filling the ring with traffic. Multicast acceptance is reached by computing the hash of a chosen group address in the bench, then setting exactly that table bit, or every bit except it.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DST, ST_DECIDE, ST_DATA, ST_PAD, ST_HDR, ST_DROP
  } rxw_state_e;

  localparam int MODE_BCAST   = 0;
  localparam int MODE_MCAST   = 1;
  localparam int MODE_PROMISC = 2;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // MSB-first register, data bits fed LSB first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/rxw_crc_hash.sv
module rxw_crc_hash import rxw_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [5:0] idx_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (clr_i)  crc_q <= '1;
    else if (en_i)   crc_q <= crc_step(crc_q, byte_i);
  end

  assign idx_o = crc_q[31:26];
endmodule

// File: rtl/rxw_addr_filter.sv
module rxw_addr_filter import rxw_pkg::*; (
  input  logic [47:0] dst_i,
  input  logic [47:0] sta_i,
  input  logic [2:0]  mode_i,
  input  logic [63:0] hash_i,
  input  logic [5:0]  idx_i,
  output logic        accept_o
);
  logic is_bcast, is_grp;

  assign is_bcast = &dst_i;
  assign is_grp   = dst_i[0];

  always_comb begin
    if (mode_i[MODE_PROMISC]) accept_o = 1'b1;
    else if (is_bcast)        accept_o = mode_i[MODE_BCAST];
    else if (is_grp)          accept_o = mode_i[MODE_MCAST] & hash_i[idx_i];
    else                      accept_o = (dst_i == sta_i);
  end
endmodule

// File: rtl/rxw_ring_calc.sv
module rxw_ring_calc #(
  parameter int PG_W       = 8,
  parameter int LEN_W      = 12,
  parameter int CRC_LEN    = 4,
  parameter int FULL_BYTES = 1518
) (
  input  logic [PG_W-1:0]  chk_pg_i,
  input  logic [PG_W-1:0]  frm_pg_i,
  input  logic [PG_W-1:0]  start_pg_i,
  input  logic [PG_W-1:0]  stop_pg_i,
  input  logic [PG_W-1:0]  bnd_pg_i,
  input  logic [LEN_W-1:0] tot_len_i,
  output logic             full_o,
  output logic [PG_W-1:0]  next_pg_o
);
  localparam int AW = PG_W + 10;
  localparam int NW = PG_W + 2;
  localparam int SW = LEN_W + 2;

  logic [AW-1:0] cur_a, bnd_a, ring_a, avail;
  logic [NW-1:0] span_pg, ring_pg, sum_pg;

  always_comb begin
    cur_a  = AW'({chk_pg_i, 8'h00});
    bnd_a  = AW'({bnd_pg_i, 8'h00});
    ring_a = AW'({stop_pg_i, 8'h00}) - AW'({start_pg_i, 8'h00});
    if (cur_a < bnd_a) avail = bnd_a - cur_a;
    else               avail = ring_a - (cur_a - bnd_a);
    // msb set means the subtraction went negative
    full_o = (stop_pg_i <= start_pg_i) || avail[AW-1] || (avail < AW'(FULL_BYTES));
  end

  always_comb begin
    span_pg = NW'((SW'(tot_len_i) + SW'(CRC_LEN + 255)) >> 8);
    ring_pg = NW'(stop_pg_i) - NW'(start_pg_i);
    sum_pg  = NW'(frm_pg_i) + span_pg;
    next_pg_o = (sum_pg >= NW'(stop_pg_i)) ? PG_W'(sum_pg - ring_pg) : PG_W'(sum_pg);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer import rxw_pkg::*; #(
  parameter int PG_W      = 8,
  parameter int LEN_W     = 12,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  parameter int HDR_LEN   = 4,
  parameter int CRC_LEN   = 4,
  localparam int ADDR_W   = PG_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic [2:0]        rx_mode_i,
  input  logic [PG_W-1:0]   ring_start_pg_i,
  input  logic [PG_W-1:0]   ring_stop_pg_i,
  input  logic [PG_W-1:0]   bnd_pg_i,
  input  logic [PG_W-1:0]   cur_pg_i,
  input  logic [47:0]       sta_addr_i,
  input  logic [63:0]       mc_hash_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [PG_W-1:0]   cur_pg_o,
  output logic [7:0]        rx_status_o,
  output logic              rx_done_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] DST_L = LEN_W'(5);
  localparam int FULL_BYTES = MAX_FRAME + HDR_LEN;

  rxw_state_e        state_q;
  logic [LEN_W-1:0]  len_q, tot_len;
  logic [ADDR_W-1:0] wr_addr_q, wr_adv, start_a, stop_a, hdr_a;
  logic [PG_W-1:0]   fpg_q, next_pg;
  logic [47:0]       dst_q;
  logic [1:0]        hidx_q;
  logic              ended_q, hs, ring_full, accept;
  logic [5:0]        hash_idx;
  logic [7:0]        status_b;
  logic [15:0]       tot16;

  assign start_a  = {ring_start_pg_i, 8'h00};
  assign stop_a   = {ring_stop_pg_i, 8'h00};
  assign hdr_a    = {fpg_q, 8'h00} + ADDR_W'(hidx_q);
  assign wr_adv   = (wr_addr_q + 1'b1 == stop_a) ? start_a : wr_addr_q + 1'b1;
  assign tot_len  = len_q + LEN_W'(HDR_LEN);
  assign tot16    = 16'(tot_len);
  assign status_b = dst_q[0] ? 8'h21 : 8'h01;
  assign s_ready_o = (state_q == ST_DST) || (state_q == ST_DATA) || (state_q == ST_DROP);
  assign hs = s_valid_i & s_ready_o;

  rxw_crc_hash u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .en_i   ((state_q == ST_DST) && hs),
    .byte_i (s_data_i),
    .idx_o  (hash_idx)
  );

  rxw_addr_filter u_filt (
    .dst_i    (dst_q),
    .sta_i    (sta_addr_i),
    .mode_i   (rx_mode_i),
    .hash_i   (mc_hash_i),
    .idx_i    (hash_idx),
    .accept_o (accept)
  );

  rxw_ring_calc #(
    .PG_W(PG_W), .LEN_W(LEN_W), .CRC_LEN(CRC_LEN), .FULL_BYTES(FULL_BYTES)
  ) u_ring (
    .chk_pg_i   (cur_pg_i),
    .frm_pg_i   (fpg_q),
    .start_pg_i (ring_start_pg_i),
    .stop_pg_i  (ring_stop_pg_i),
    .bnd_pg_i   (bnd_pg_i),
    .tot_len_i  (tot_len),
    .full_o     (ring_full),
    .next_pg_o  (next_pg)
  );

  always_comb begin
    mem_we_o   = 1'b0;
    mem_addr_o = wr_addr_q;
    mem_data_o = s_data_i;
    unique case (state_q)
      ST_DST:  mem_we_o = hs;
      ST_DATA: mem_we_o = s_valid_i && (len_q != MAX_L);
      ST_PAD: begin
        mem_we_o   = 1'b1;
        mem_data_o = 8'h00;
      end
      ST_HDR: begin
        mem_we_o   = 1'b1;
        mem_addr_o = hdr_a;
        unique case (hidx_q)
          2'd0:    mem_data_o = status_b;
          2'd1:    mem_data_o = 8'(next_pg);
          2'd2:    mem_data_o = tot16[7:0];
          default: mem_data_o = tot16[15:8];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      len_q       <= '0;
      wr_addr_q   <= '0;
      fpg_q       <= '0;
      dst_q       <= '0;
      hidx_q      <= '0;
      ended_q     <= 1'b0;
      cur_pg_o    <= '0;
      rx_status_o <= '0;
      rx_done_o   <= 1'b0;
    end else begin
      rx_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (s_valid_i) begin
          fpg_q     <= cur_pg_i;
          wr_addr_q <= {cur_pg_i, 8'h00} + ADDR_W'(HDR_LEN);
          len_q     <= '0;
          hidx_q    <= '0;
          ended_q   <= 1'b0;
          state_q   <= (halt_i || ring_full) ? ST_DROP : ST_DST;
        end
        ST_DST: if (hs) begin
          // destination bytes are stored speculatively; header is written only on accept
          dst_q[8*len_q[2:0] +: 8] <= s_data_i;
          len_q     <= len_q + 1'b1;
          wr_addr_q <= wr_adv;
          if (len_q == DST_L) begin
            ended_q <= s_last_i;
            state_q <= ST_DECIDE;
          end else if (s_last_i) begin
            state_q <= ST_IDLE;
          end
        end
        ST_DECIDE: begin
          if (accept) state_q <= ended_q ? ST_PAD : ST_DATA;
          else        state_q <= ended_q ? ST_IDLE : ST_DROP;
        end
        ST_DATA: if (s_valid_i) begin
          if (len_q == MAX_L) begin
            state_q <= s_last_i ? ST_IDLE : ST_DROP;
          end else begin
            len_q     <= len_q + 1'b1;
            wr_addr_q <= wr_adv;
            if (s_last_i) state_q <= (len_q + 1'b1 < MIN_L) ? ST_PAD : ST_HDR;
          end
        end
        ST_PAD: begin
          len_q     <= len_q + 1'b1;
          wr_addr_q <= wr_adv;
          if (len_q + 1'b1 == MIN_L) state_q <= ST_HDR;
        end
        ST_HDR: begin
          hidx_q <= hidx_q + 1'b1;
          if (hidx_q == 2'd3) begin
            state_q     <= ST_IDLE;
            rx_done_o   <= 1'b1;
            cur_pg_o    <= next_pg;
            rx_status_o <= status_b;
          end
        end
        ST_DROP: if (hs && s_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  a_r1_halt_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && s_valid_i && halt_i) |=> !mem_we_o);
  // R2
  a_r2_full_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && s_valid_i && ring_full) |=> !mem_we_o);
  // R10
  a_r10_addr_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o >= start_a && mem_addr_o < stop_a));
  // R11
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);
  a_r11_cur_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_done_o |-> $stable(cur_pg_o));
  a_r8_done_after_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> $past(mem_we_o));
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic [2:0]  mode = 3'b000;
  logic [7:0]  start_pg = 8'h40, stop_pg = 8'h60, bnd_pg = 8'h40, cur_pg = 8'h40;
  logic [47:0] sta = 48'h55_44_33_22_11_02;
  logic [63:0] hash = '0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready, mem_we, rx_done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data, cur_pg_o, rx_status;

  int checks = 0, errors = 0, wr_count = 0, done_count = 0;
  logic [7:0]  bmem [int];
  logic [15:0] exp_q [$];

  always #2 clk = ~clk;

  rx_ring_writer uut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .rx_mode_i(mode),
    .ring_start_pg_i(start_pg), .ring_stop_pg_i(stop_pg), .bnd_pg_i(bnd_pg),
    .cur_pg_i(cur_pg), .sta_addr_i(sta), .mc_hash_i(hash),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .cur_pg_o(cur_pg_o), .rx_status_o(rx_status), .rx_done_o(rx_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: capture memory writes, pop scoreboard on completion
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      bmem[int'(mem_addr)] = mem_data;
      wr_count++;
    end
    if (rst_n && rx_done) begin
      done_count++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", int'(cur_pg_o), 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(cur_pg_o == e[15:8], "R11 cur_pg_o", int'(cur_pg_o), int'(e[15:8]));
        chk(rx_status == e[7:0], "R8 status", int'(rx_status), int'(e[7:0]));
      end
    end
  end

  function automatic logic [5:0] hash_of(input logic [47:0] d);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      fb = c[31] ^ d[k];
      c  = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [7:0] rd(input int a);
    if (bmem.exists(a)) return bmem[a];
    return 8'hxx;
  endfunction

  // acc: expected to be stored; nowr: expected to cause no memory write at all
  task automatic send(input logic [47:0] dst, input int n, input bit acc, input bit nowr,
                      input string req);
    logic [7:0] fr [$];
    int wr0, dn0, pad, tot, nxt, bad_a, bad_v, bad_e, nbad;
    logic [7:0] st;
    fr = {};
    for (int k = 0; k < n; k++) fr.push_back(k < 6 ? dst[8*k +: 8] : 8'((k * 13 + n) | 1));
    pad = (n < 60) ? 60 : n;
    tot = pad + 4;
    nxt = int'(cur_pg) + (tot + 4 + 255) / 256;
    if (nxt >= int'(stop_pg)) nxt -= int'(stop_pg) - int'(start_pg);
    st  = dst[0] ? 8'h21 : 8'h01;
    if (acc) exp_q.push_back({8'(nxt), st});
    wr0 = wr_count;
    dn0 = done_count;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      bit hs;
      s_valid = 1'b1;
      s_data  = fr[k];
      s_last  = (k == n - 1);
      do begin
        hs = s_ready;
        @(negedge clk);
      end while (!hs);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    repeat (80) @(negedge clk);
    if (acc) begin
      int base;
      base = int'(cur_pg) * 256;
      chk(done_count == dn0 + 1, {req, " done count"}, done_count - dn0, 1);
      chk(rd(base) === st, "R8 header status", int'(rd(base)), int'(st));
      chk(rd(base + 1) === 8'(nxt), "R9 header next page", int'(rd(base + 1)), nxt);
      chk(rd(base + 2) === 8'(tot), "R7 header len lo", int'(rd(base + 2)), tot & 255);
      chk(rd(base + 3) === 8'(tot >> 8), "R7 header len hi", int'(rd(base + 3)), tot >> 8);
      nbad = 0; bad_a = 0; bad_v = 0; bad_e = 0;
      for (int k = 0; k < pad; k++) begin
        int a;
        logic [7:0] e;
        a = base + 4 + k;
        if (a >= int'(stop_pg) * 256) a -= (int'(stop_pg) - int'(start_pg)) * 256;
        e = (k < n) ? fr[k] : 8'h00;
        if (rd(a) !== e) begin
          if (nbad == 0) begin bad_a = a; bad_v = int'(rd(a)); bad_e = int'(e); end
          nbad++;
        end
      end
      chk(nbad == 0, {req, " R10 payload at ring address"}, bad_v, bad_e);
      if (nbad != 0) $display("  first bad address %0h", bad_a);
      cur_pg = 8'(nxt);
    end else begin
      chk(done_count == dn0, {req, " no done"}, done_count - dn0, 0);
      if (nowr) chk(wr_count == wr0, {req, " no write"}, wr_count - wr0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] mc;
    logic [5:0]  h;
    repeat (3) @(negedge clk);
    chk(mem_we == 1'b0, "R11 reset no write", int'(mem_we), 0);
    chk(rx_done == 1'b0, "R11 reset no done", int'(rx_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_pg_o == 8'h00, "R11 reset cur_pg_o", int'(cur_pg_o), 0);
    chk(rx_status == 8'h00, "R11 reset status", int'(rx_status), 0);

    send(sta, 64, 1'b1, 1'b0, "R6 unicast match");
    send(sta ^ 48'h01_0000_0000_00, 64, 1'b0, 1'b0, "R6 unicast mismatch");
    send('1, 100, 1'b0, 1'b0, "R4 broadcast disabled");
    mode = 3'b001;
    send('1, 100, 1'b1, 1'b0, "R4 broadcast enabled");

    mc = 48'h01_00_00_5E_00_01;
    h  = hash_of(mc);
    mode = 3'b010;
    hash = 64'd1 << h;
    send(mc, 70, 1'b1, 1'b0, "R5 multicast hash hit");
    hash = ~(64'd1 << h);
    send(mc, 70, 1'b0, 1'b0, "R5 multicast hash miss");
    mode = 3'b001;
    hash = '1;
    send(mc, 70, 1'b0, 1'b0, "R5 multicast mode off");

    mode = 3'b100;
    send(48'h99_88_77_66_55_A4, 80, 1'b1, 1'b0, "R3 promiscuous");
    mode = 3'b000;

    send(sta, 20, 1'b1, 1'b0, "R7 short frame pad");
    send(sta, 4, 1'b0, 1'b0, "R12 runt");
    send(sta, 1515, 1'b0, 1'b0, "R12 oversize");
    send(sta, 1514, 1'b1, 1'b0, "R12 maximum size");

    cur_pg = 8'h5F; bnd_pg = 8'h50;
    send(sta, 300, 1'b1, 1'b0, "R10 ring wrap");
    chk(cur_pg_o == 8'h41, "R9 wrapped next page", int'(cur_pg_o), 8'h41);

    cur_pg = 8'h40; bnd_pg = 8'h45;
    send(sta, 64, 1'b0, 1'b1, "R2 free 1280");
    bnd_pg = 8'h46;
    send(sta, 64, 1'b1, 1'b0, "R2 free 1536");

    start_pg = 8'h60; bnd_pg = 8'h60; cur_pg = 8'h60;
    send(sta, 64, 1'b0, 1'b1, "R2 stop not above start");
    start_pg = 8'h40; bnd_pg = 8'h40; cur_pg = 8'h40;

    halt = 1'b1;
    send(sta, 64, 1'b0, 1'b1, "R1 halted");
    halt = 1'b0;
    send(sta, 64, 1'b1, 1'b0, "R1 resumed");

    chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule